// File: doc/BRIEF.md
# Dual-Channel High-Side Switch Protection Controller

This block holds the digital control and fault handling for two high-side power switches. Each channel takes an active-high command and a digitized overcurrent comparator flag. It produces three outputs: a gate enable for the external switch, an active-low latched fault indication, and an active-low live indication of the comparator state. All outputs are registered. A shared inhibit input and a shared supply-drop flag turn every gate off at once. The supply-drop flag arrives already filtered through hysteresis.

Every asynchronous input passes through a two-flop synchronizer before the logic sees it. When a channel's command rises, a blanking timer starts. For a parameterized number of clock cycles it hides the overcurrent flag, while the external switch is still turning on and its drain-source voltage is naturally high. After that window, an overcurrent seen while the gate is on trips the channel. The gate is then held off until the command goes low. The fault indication stays asserted until the next command rising edge.

Top module: `hs_protect_ctrl`

## Requirements
- R1: The channels are independent: command and overcurrent activity on one channel never changes the gate or fault outputs of the other.
- R2: With inhibit low, supply-drop low and no trip, `gate_en_o[n]` goes high on the third rising clock edge after `cmd_i[n]` rises (two synchronizer edges plus one output register). It goes low with the same latency when the command falls.
- R3: While `inhibit_i` is high, every gate enable is low whatever the commands are, with a three-edge latency from the input. The inhibit synchronizer resets to the inhibiting value.
- R4: While `uv_i` (supply-drop flag, 1 = supply too low) is high, every gate enable is low, with a three-edge latency from the input.
- R5: An overcurrent flag seen outside the blanking window while the channel's gate would be on trips the channel. The gate drops on the third edge after `oc_i[n]` rises and stays low even after the flag clears, for as long as the command stays high.
- R6: A trip is released by the command going low. The next command rise turns the gate back on with the R2 latency.
- R7: `fault_n_o[n]` goes low on the same edge that the trip turns the gate off. It stays low through the command falling and goes high only on the third edge after the next command rise.
- R8: Overcurrent is masked for exactly BLANK_CYCLES clock edges, starting with the edge on which the synchronized command rise is seen. With overcurrent held high from the command rise, the gate is high after edge BLANK_CYCLES+2 and low after edge BLANK_CYCLES+3, counted from the input change.
- R9: The blanking window is cancelled when the command falls, and it restarts in full on every command rise.
- R10: `status_n_o[n]` is the inverse of the synchronized overcurrent flag (low = drain-source voltage above threshold). It is registered with a three-edge latency and is updated whatever the gate state.
- R11: An overcurrent flag while the channel's gate is off, either because the command is low or because the channel is inhibited, causes no trip and no fault.
- R12: During synchronous reset, all gate enables are low and all fault and status outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | NCH | Per-channel active-high switch command |
| oc_i | input | NCH | Per-channel overcurrent comparator flag (1 = over threshold) |
| inhibit_i | input | 1 | Shared inhibit, 1 forces all gates off |
| uv_i | input | 1 | Shared supply-drop flag, 1 forces all gates off |
| gate_en_o | output | NCH | Per-channel gate enable |
| fault_n_o | output | NCH | Per-channel latched fault, active low |
| status_n_o | output | NCH | Per-channel live comparator state, active low |

## Verification
Every input reaches the outputs after exactly three rising edges: two in the synchronizer and one in the output register. So gate, fault and status changes caused by a command, inhibit, supply-drop or overcurrent input are due three cycles after the driver changes it. The one exception is a trip held back by blanking, which lands BLANK_CYCLES+3 cycles after the command rise. The driver tags each expected value with the cycle number it is due in. The monitor compares it on the falling edge of that cycle, and for the blanking boundary it also checks the cycle just before.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef struct packed {
    logic gate;
    logic fault_n;
    logic status_n;
  } hsp_chan_out_t;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= {W{RST_VAL}};
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hsp_channel.sv
module hsp_channel
  import hsp_pkg::*;
#(
  parameter int BLANK_CYCLES = 1500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_s,
  input  logic          oc_s,
  input  logic          block_s,
  output hsp_chan_out_t out
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYCLES - 1);

  logic          cmd_d;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          trip_q, trip_nxt;
  logic          fault_q, fault_nxt;
  logic          gate_q, status_n_q;
  logic          rise, masked, arm, trip_set;

  assign rise     = cmd_s & ~cmd_d;
  assign masked   = rise | (cnt_q != '0);
  assign arm      = cmd_s & ~block_s & ~trip_q;
  assign trip_set = arm & oc_s & ~masked;
  assign trip_nxt = cmd_s & (trip_q | trip_set);

  always_comb begin
    if (!cmd_s)            cnt_nxt = '0;
    else if (rise)         cnt_nxt = LOAD;
    else if (cnt_q != '0)  cnt_nxt = cnt_q - 1'b1;
    else                   cnt_nxt = '0;
  end

  always_comb begin
    if (trip_set)   fault_nxt = 1'b1;
    else if (rise)  fault_nxt = 1'b0;
    else            fault_nxt = fault_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_d      <= 1'b0;
      cnt_q      <= '0;
      trip_q     <= 1'b0;
      fault_q    <= 1'b0;
      gate_q     <= 1'b0;
      status_n_q <= 1'b1;
    end else begin
      cmd_d      <= cmd_s;
      cnt_q      <= cnt_nxt;
      trip_q     <= trip_nxt;
      fault_q    <= fault_nxt;
      gate_q     <= arm & ~trip_set;
      status_n_q <= ~oc_s;
    end
  end

  assign out.gate     = gate_q;
  assign out.fault_n  = ~fault_q;
  assign out.status_n = status_n_q;

  // R8
  blank_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (masked && !trip_q) |=> !trip_q);
  // R5
  trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trip_q && cmd_s) |=> (trip_q && !gate_q));
  // R7
  fault_release_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !rise) |=> fault_q);
  // R10
  status_live_chk: assert property (@(posedge clk) disable iff (rst)
    oc_s |=> !status_n_q);
  // R11
  no_trip_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!trip_q && (!cmd_s || block_s)) |=> !trip_q);
endmodule

// File: rtl/hs_protect_ctrl.sv
module hs_protect_ctrl
  import hsp_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SYNC_STAGES = 2,
  parameter int BLANK_CYCLES = 1500
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cmd_i,
  input  logic [NCH-1:0] oc_i,
  input  logic           inhibit_i,
  input  logic           uv_i,
  output logic [NCH-1:0] gate_en_o,
  output logic [NCH-1:0] fault_n_o,
  output logic [NCH-1:0] status_n_o
);
  logic [NCH-1:0] cmd_s, oc_s;
  logic           inh_s, uv_s, block_s;
  hsp_chan_out_t  ch_out [NCH];

  hsp_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cmd_sync (
    .clk(clk), .rst(rst), .d(cmd_i), .q(cmd_s));
  hsp_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_oc_sync (
    .clk(clk), .rst(rst), .d(oc_i), .q(oc_s));
  hsp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_inh_sync (
    .clk(clk), .rst(rst), .d(inhibit_i), .q(inh_s));
  hsp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_uv_sync (
    .clk(clk), .rst(rst), .d(uv_i), .q(uv_s));

  assign block_s = inh_s | uv_s;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hsp_channel #(.BLANK_CYCLES(BLANK_CYCLES)) u_ch (
      .clk(clk), .rst(rst),
      .cmd_s(cmd_s[g]), .oc_s(oc_s[g]), .block_s(block_s),
      .out(ch_out[g]));
    assign gate_en_o[g]  = ch_out[g].gate;
    assign fault_n_o[g]  = ch_out[g].fault_n;
    assign status_n_o[g] = ch_out[g].status_n;
  end

  // R3
  inhibit_off_chk: assert property (@(posedge clk) disable iff (rst)
    inh_s |=> (gate_en_o == '0));
  // R4
  uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    uv_s |=> (gate_en_o == '0));
  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (gate_en_o == '0 && fault_n_o == '1 && status_n_o == '1));
endmodule

// File: tb/tb_hs_protect_ctrl.sv
module tb_hs_protect_ctrl;
  localparam int NCH = 2;
  localparam int B = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] cmd = '0, oc = '0;
  logic inh = 1'b0, uv = 1'b0;
  logic [NCH-1:0] gate, fault_n, status_n;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    int    kind;   // 0 gate, 1 fault_n, 2 status_n
    int    ch;
    logic  val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hs_protect_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .BLANK_CYCLES(B)) dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .oc_i(oc),
    .inhibit_i(inh), .uv_i(uv),
    .gate_en_o(gate), .fault_n_o(fault_n), .status_n_o(status_n));

  function automatic logic actual(int kind, int ch);
    case (kind)
      0: return gate[ch];
      1: return fault_n[ch];
      default: return status_n[ch];
    endcase
  endfunction

  task automatic expect_at(int delay, int kind, int ch, logic val, string tag);
    exp_t e;
    e.due = cyc + delay; e.kind = kind; e.ch = ch; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic a;
        a = actual(q[i].kind, q[i].ch);
        checks++;
        if (a !== q[i].val) begin
          errors++;
          $display("FAIL %s kind=%0d ch=%0d cyc=%0d actual=%b expected=%b",
                   q[i].tag, q[i].kind, q[i].ch, cyc, a, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  // driver
  initial begin
    wait_n(2);
    // R12 reset state
    for (int c = 0; c < NCH; c++) begin
      expect_at(1, 0, c, 1'b0, "R12");
      expect_at(1, 1, c, 1'b1, "R12");
      expect_at(1, 2, c, 1'b1, "R12");
    end
    wait_n(3);
    rst = 1'b0;
    wait_n(4);

    // R2 turn-on, R1 other channel quiet
    cmd[0] = 1'b1;
    expect_at(2, 0, 0, 1'b0, "R2");
    expect_at(3, 0, 0, 1'b1, "R2");
    expect_at(3, 0, 1, 1'b0, "R1");
    expect_at(3, 1, 0, 1'b1, "R2");
    wait_n(B + 6);

    // R3 inhibit
    inh = 1'b1;
    expect_at(2, 0, 0, 1'b1, "R3");
    expect_at(3, 0, 0, 1'b0, "R3");
    wait_n(5);
    inh = 1'b0;
    expect_at(3, 0, 0, 1'b1, "R3");
    wait_n(5);

    // R4 supply drop
    uv = 1'b1;
    expect_at(3, 0, 0, 1'b0, "R4");
    wait_n(5);
    uv = 1'b0;
    expect_at(3, 0, 0, 1'b1, "R4");
    wait_n(5);

    // R5 trip after blanking, R7 fault, R10 status
    oc[0] = 1'b1;
    expect_at(2, 0, 0, 1'b1, "R5");
    expect_at(3, 0, 0, 1'b0, "R5");
    expect_at(3, 1, 0, 1'b0, "R7");
    expect_at(3, 2, 0, 1'b0, "R10");
    expect_at(3, 0, 1, 1'b0, "R1");
    expect_at(3, 1, 1, 1'b1, "R1");
    wait_n(5);
    oc[0] = 1'b0;
    expect_at(3, 2, 0, 1'b1, "R10");
    expect_at(4, 0, 0, 1'b0, "R5");
    wait_n(5);

    // R7 fault held through command low
    cmd[0] = 1'b0;
    expect_at(5, 1, 0, 1'b0, "R7");
    expect_at(5, 0, 0, 1'b0, "R6");
    wait_n(6);

    // R8 blanking boundary, R7 release on rise
    cmd[0] = 1'b1; oc[0] = 1'b1;
    expect_at(3, 1, 0, 1'b1, "R7");
    expect_at(3, 0, 0, 1'b1, "R8");
    expect_at(B + 2, 0, 0, 1'b1, "R8");
    expect_at(B + 3, 0, 0, 1'b0, "R8");
    expect_at(B + 3, 1, 0, 1'b0, "R8");
    wait_n(B + 6);
    cmd[0] = 1'b0; oc[0] = 1'b0;
    wait_n(5);

    // R6 re-enable after trip released
    cmd[0] = 1'b1;
    expect_at(3, 0, 0, 1'b1, "R6");
    expect_at(3, 1, 0, 1'b1, "R6");
    wait_n(B + 6);

    // R9 window cancelled on fall, restarted on rise
    cmd[0] = 1'b0;
    wait_n(5);
    cmd[0] = 1'b1;
    wait_n(10);
    cmd[0] = 1'b0;
    wait_n(3);
    cmd[0] = 1'b1; oc[0] = 1'b1;
    expect_at(B + 2, 0, 0, 1'b1, "R9");
    expect_at(B + 3, 0, 0, 1'b0, "R9");
    wait_n(B + 6);
    cmd[0] = 1'b0; oc[0] = 1'b0;
    wait_n(5);
    cmd[0] = 1'b1;
    expect_at(3, 1, 0, 1'b1, "R9");
    wait_n(B + 6);
    cmd[0] = 1'b0;
    wait_n(5);

    // R11 overcurrent with command low
    oc[0] = 1'b1;
    expect_at(3, 2, 0, 1'b0, "R11");
    expect_at(5, 1, 0, 1'b1, "R11");
    wait_n(6);
    oc[0] = 1'b0;
    wait_n(4);

    // R11 overcurrent while inhibited
    cmd[0] = 1'b1;
    wait_n(B + 6);
    inh = 1'b1;
    wait_n(4);
    oc[0] = 1'b1;
    expect_at(4, 1, 0, 1'b1, "R11");
    expect_at(4, 0, 0, 1'b0, "R11");
    wait_n(5);
    oc[0] = 1'b0;
    wait_n(4);
    inh = 1'b0;
    expect_at(3, 0, 0, 1'b1, "R11");
    expect_at(3, 1, 0, 1'b1, "R11");
    wait_n(5);

    // R1 channel 1 trips, channel 0 untouched
    cmd[1] = 1'b1; oc[1] = 1'b1;
    expect_at(3, 0, 1, 1'b1, "R1");
    expect_at(B + 3, 0, 1, 1'b0, "R1");
    expect_at(B + 3, 1, 1, 1'b0, "R1");
    expect_at(B + 3, 0, 0, 1'b1, "R1");
    expect_at(B + 3, 1, 0, 1'b1, "R1");
    wait_n(B + 6);

    while (q.size() != 0) wait_n(1);
    summary();
  end
endmodule